// File: doc/BRIEF.md
# UDP Datagram Detector

This block sits on a 32-bit word stream that has already passed IP-level processing. It tells UDP packets from all other traffic by the protocol byte of the IP header, and marks the first UDP header word with a one-cycle start-of-datagram strobe. It checks the checksum of every received UDP datagram and writes a freshly computed checksum into the outgoing copy of the datagram. Words with data-enable low are idle: they flow through but take no part in parsing or summing.

The checksum cannot be known before the whole datagram has gone by, but the checksum field sits near the front of it. For that reason the stream passes through a fixed delay line held in one inferable RAM. The checksum is computed on the input side and then placed into the field as it leaves the delay line. A frame consists of the IP header words (the first one flagged by start-of-frame), the UDP header and payload (the first UDP word flagged by the incoming start-of-payload strobe), an end-of-frame strobe on the last datagram word, and two trailer words.

Top module: `udp_datagram_detector`

## Requirements
- R1: A packet counts as UDP only when bits 23:16 of the third data-enabled word of the frame equal exactly 17. Any other value, including values that share bits with 17, makes the packet non-UDP.
- R2: For a UDP packet, `out_sod` is high for exactly one cycle. That cycle is the output copy of the word that carried `in_sop`, which is the first UDP header word.
- R3: For a non-UDP packet, `out_sod` and `out_cksum_err` stay low and every output word equals its input word.
- R4: Every output (`out_data`, `out_den`, `out_sof`, `out_eof`) reproduces its input exactly 2^ADDR_W + 1 clock cycles later. The only exception is the checksum field of R5.
- R5: In a UDP packet, bits 15:0 of the second datagram word leave holding the one's-complement of the 16-bit end-around-carry sum. That sum covers the source address (fourth word), the destination address (fifth word), the value 17, the UDP length (bits 31:16 of the second datagram word) and every 16-bit half of every datagram word from the header to the end-of-frame word, with the checksum field taken as zero. A computed value of 0 is sent as 0xFFFF.
- R6: When the received checksum is non-zero and does not match, `out_cksum_err` is high for one cycle, together with `out_eof` of that packet. It is low at every other time.
- R7: A received checksum of 0 never raises `out_cksum_err`. The outgoing field is still filled in as in R5.
- R8: Cycles with data-enable low change neither word positions nor the sum. Such cycles may fall anywhere inside a frame.
- R9: After reset, and until the delay line has filled once, all outputs are zero.
- R10: The two data-enabled trailer words after end-of-frame are not summed and pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input word |
| in_den | input | 1 | Input word valid (header, datagram and trailer) |
| in_sof | input | 1 | First IP header word |
| in_sop | input | 1 | First word after the IP header |
| in_eof | input | 1 | Last datagram word |
| out_data | output | DATA_W | Delayed word, with the checksum field rewritten for UDP |
| out_den | output | 1 | Delayed word valid |
| out_sof | output | 1 | Delayed start of frame |
| out_sod | output | 1 | First UDP header word |
| out_eof | output | 1 | Delayed end of frame |
| out_cksum_err | output | 1 | Received UDP checksum wrong, with `out_eof` |

## Verification
The sweep sends protocol bytes of 17 and of near neighbours such as 0x91, 0x10 and 0x13. This separates an exact protocol compare from a compare that looks at only some of the bits. Each UDP packet is sent with a correct, a zero and a corrupted received checksum, which tells the error flag apart from the zero-means-absent rule; the outgoing field must be the same in all three cases. Header lengths of five and six words move the start-of-payload word, and payload lengths from zero to thirty words include one where the checksum word is also the end-of-frame word. Idle cycles with junk data on the bus are placed inside frames, and a long frame nearly fills the delay window, so any leak of idle or trailer words into the sum changes the checksum.

// File: rtl/udpd_pkg.sv
package udpd_pkg;
  localparam int unsigned HALF_W = 16;
  localparam logic [7:0] PROTO_UDP = 8'd17;

  typedef enum logic [1:0] {
    ADD_NONE,
    ADD_BOTH,
    ADD_CKW
  } add_kind_e;

  typedef struct packed {
    logic        err;
    logic [15:0] fill;
  } result_t;

  // end-around-carry reduction of a 32-bit sum to 16 bits
  function automatic logic [15:0] fold32(input logic [31:0] x);
    logic [16:0] t;
    logic [16:0] r;
    t = {1'b0, x[15:0]} + {1'b0, x[31:16]};
    r = {1'b0, t[15:0]} + {16'd0, t[16]};
    return r[15:0];
  endfunction
endpackage

// File: rtl/udpd_parse.sv
module udpd_parse
  import udpd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data,
  input  logic              den,
  input  logic              sof,
  input  logic              sop,
  input  logic              eof,
  output logic              sod_now,
  output logic              ckw_now,
  output logic              ueof_now,
  output logic              clr_now,
  output add_kind_e         kind
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_PROTO = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_SRC = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_DST = IDX_W'(4);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] cur_idx;
  logic             udp_q;
  logic             in_dg_q;
  logic [1:0]       dg_cnt_q;

  assign cur_idx  = sof ? '0 : idx_q;
  assign sod_now  = den & sop & udp_q & ~sof;
  assign ckw_now  = den & in_dg_q & (dg_cnt_q == 2'd1);
  assign ueof_now = den & eof & (in_dg_q | sod_now);
  assign clr_now  = den & sof;

  always_comb begin
    kind = ADD_NONE;
    if (den && !sof) begin
      if (cur_idx == IDX_SRC || cur_idx == IDX_DST) kind = ADD_BOTH;
      else if (ckw_now)                              kind = ADD_CKW;
      else if (sod_now || in_dg_q)                   kind = ADD_BOTH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      udp_q    <= 1'b0;
      in_dg_q  <= 1'b0;
      dg_cnt_q <= 2'd0;
    end else if (den) begin
      if (sof)                  idx_q <= IDX_W'(1);
      else if (idx_q != IDX_MAX) idx_q <= idx_q + IDX_W'(1);

      if (sof)                         udp_q <= 1'b0;
      else if (cur_idx == IDX_PROTO)   udp_q <= (data[HALF_W+7:HALF_W] == PROTO_UDP);

      if (sof || eof)   in_dg_q <= 1'b0;
      else if (sod_now) in_dg_q <= 1'b1;

      if (sod_now)                          dg_cnt_q <= 2'd1;
      else if (in_dg_q && dg_cnt_q != 2'd2) dg_cnt_q <= dg_cnt_q + 2'd1;
    end
  end
endmodule

// File: rtl/udpd_csum.sv
module udpd_csum
  import udpd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  add_kind_e         kind,
  input  logic [DATA_W-1:0] data,
  input  logic              fin,
  output logic              push,
  output result_t           res
);
  logic [HALF_W-1:0] hi, lo;
  logic [ACC_W-1:0]  add_v;
  logic [ACC_W-1:0]  acc_q;
  logic [15:0]       rx_q;
  logic              fin_q;
  logic [15:0]       s;
  logic [16:0]       t;
  logic [15:0]       chk;

  assign hi = data[DATA_W-1:HALF_W];
  assign lo = data[HALF_W-1:0];

  always_comb begin
    case (kind)
      ADD_BOTH: add_v = ACC_W'(hi) + ACC_W'(lo);
      ADD_CKW:  add_v = ACC_W'(hi) + ACC_W'(hi) + ACC_W'(PROTO_UDP);
      default:  add_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      rx_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin;
      if (clr) acc_q <= '0;
      else     acc_q <= acc_q + add_v;
      if (kind == ADD_CKW) rx_q <= lo;
    end
  end

  assign s    = fold32(32'(acc_q));
  assign t    = {1'b0, s} + {1'b0, rx_q};
  assign chk  = fold32({15'd0, t});
  assign push = fin_q;

  always_comb begin
    res.err  = (rx_q != 16'd0) && (chk != 16'hFFFF);
    res.fill = (~s == 16'd0) ? 16'hFFFF : ~s;
  end
endmodule

// File: rtl/udpd_res_fifo.sv
module udpd_res_fifo
  import udpd_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  result_t din,
  input  logic    pop,
  output result_t head,
  output logic    empty,
  output logic    full
);
  localparam int DEPTH = 1 << PTR_W;

  result_t          mem [DEPTH];
  logic [PTR_W:0]   wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[PTR_W] != rp_q[PTR_W]) && (wp_q[PTR_W-1:0] == rp_q[PTR_W-1:0]);
  assign head  = mem[rp_q[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp_q[PTR_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) wp_q <= wp_q + 1'b1;
      if (pop && !empty) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/udpd_delay.sv
module udpd_delay #(
  parameter int W  = 38,
  parameter int AW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dvld
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q;
  logic          primed_q;

  // read-before-write single-port RAM
  always_ff @(posedge clk) begin
    dout      <= mem[wp_q];
    mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      primed_q <= 1'b0;
      dvld     <= 1'b0;
    end else begin
      wp_q <= wp_q + AW'(1);
      if (wp_q == LAST) primed_q <= 1'b1;
      dvld <= primed_q;
    end
  end
endmodule

// File: rtl/udp_datagram_detector.sv
module udp_datagram_detector
  import udpd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int FIFO_PTR_W = 3,
  parameter int ACC_W      = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_den,
  input  logic              in_sof,
  input  logic              in_sop,
  input  logic              in_eof,
  output logic [DATA_W-1:0] out_data,
  output logic              out_den,
  output logic              out_sof,
  output logic              out_sod,
  output logic              out_eof,
  output logic              out_cksum_err
);
  localparam int ENT_W  = DATA_W + 6;
  localparam int B_DEN  = DATA_W;
  localparam int B_SOF  = DATA_W + 1;
  localparam int B_EOF  = DATA_W + 2;
  localparam int B_SOD  = DATA_W + 3;
  localparam int B_UEOF = DATA_W + 4;
  localparam int B_CKW  = DATA_W + 5;

  logic       sod_now, ckw_now, ueof_now, clr_now;
  add_kind_e  kind;
  logic       res_push, res_pop, res_empty, res_full;
  result_t    res_in, res_head;
  logic [ENT_W-1:0] ent_in, ent_out;
  logic       ent_vld;

  udpd_parse #(.DATA_W(DATA_W)) u_parse (
    .clk(clk), .rst(rst), .data(in_data), .den(in_den), .sof(in_sof),
    .sop(in_sop), .eof(in_eof), .sod_now(sod_now), .ckw_now(ckw_now),
    .ueof_now(ueof_now), .clr_now(clr_now), .kind(kind)
  );

  udpd_csum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_csum (
    .clk(clk), .rst(rst), .clr(clr_now), .kind(kind), .data(in_data),
    .fin(ueof_now), .push(res_push), .res(res_in)
  );

  udpd_res_fifo #(.PTR_W(FIFO_PTR_W)) u_fifo (
    .clk(clk), .rst(rst), .push(res_push), .din(res_in), .pop(res_pop),
    .head(res_head), .empty(res_empty), .full(res_full)
  );

  assign ent_in = {ckw_now, ueof_now, sod_now, in_eof, in_sof, in_den, in_data};

  udpd_delay #(.W(ENT_W), .AW(ADDR_W)) u_delay (
    .clk(clk), .rst(rst), .din(ent_in), .dout(ent_out), .dvld(ent_vld)
  );

  assign res_pop = ent_vld & ent_out[B_UEOF];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data      <= '0;
      out_den       <= 1'b0;
      out_sof       <= 1'b0;
      out_sod       <= 1'b0;
      out_eof       <= 1'b0;
      out_cksum_err <= 1'b0;
    end else if (!ent_vld) begin
      out_data      <= '0;
      out_den       <= 1'b0;
      out_sof       <= 1'b0;
      out_sod       <= 1'b0;
      out_eof       <= 1'b0;
      out_cksum_err <= 1'b0;
    end else begin
      out_den       <= ent_out[B_DEN];
      out_sof       <= ent_out[B_SOF];
      out_sod       <= ent_out[B_SOD];
      out_eof       <= ent_out[B_EOF];
      out_cksum_err <= ent_out[B_UEOF] & ~res_empty & res_head.err;
      if (ent_out[B_CKW])
        out_data <= {ent_out[DATA_W-1:HALF_W], res_head.fill};
      else
        out_data <= ent_out[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/udpd_checker.sv
module udpd_checker (
  input logic clk,
  input logic rst,
  input logic out_den,
  input logic out_sof,
  input logic out_sod,
  input logic out_eof,
  input logic out_cksum_err,
  input logic res_push,
  input logic res_full,
  input logic res_pop,
  input logic res_empty
);
  logic seen_sod_q;

  always_ff @(posedge clk) begin
    if (rst || out_sof) seen_sod_q <= 1'b0;
    else if (out_sod)   seen_sod_q <= 1'b1;
  end

  AST_SOD_SINGLE: assert property (@(posedge clk) disable iff (rst) out_sod |=> !out_sod); // R2
  AST_SOD_ON_WORD: assert property (@(posedge clk) disable iff (rst) out_sod |-> (out_den && !out_sof)); // R2
  AST_ERR_AT_EOF: assert property (@(posedge clk) disable iff (rst) out_cksum_err |-> out_eof); // R6
  AST_ERR_ONLY_UDP: assert property (@(posedge clk) disable iff (rst) out_cksum_err |-> seen_sod_q); // R3
  AST_RES_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) res_push |-> !res_full); // R5
  AST_RES_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) res_pop |-> !res_empty); // R5
endmodule

bind udp_datagram_detector udpd_checker u_chk (
  .clk(clk), .rst(rst), .out_den(out_den), .out_sof(out_sof),
  .out_sod(out_sod), .out_eof(out_eof), .out_cksum_err(out_cksum_err),
  .res_push(res_push), .res_full(res_full), .res_pop(res_pop),
  .res_empty(res_empty)
);

// File: tb/udp_datagram_detector_test.sv
`timescale 1ns/1ps
module udp_datagram_detector_test;
  localparam int AW   = 6;
  localparam int LAT2 = (1 << AW) + 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic [31:0] in_data, out_data;
  logic        in_den, in_sof, in_sop, in_eof;
  logic        out_den, out_sof, out_sod, out_eof, out_cksum_err;

  udp_datagram_detector #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_den(in_den),
    .in_sof(in_sof), .in_sop(in_sop), .in_eof(in_eof),
    .out_data(out_data), .out_den(out_den), .out_sof(out_sof),
    .out_sod(out_sod), .out_eof(out_eof), .out_cksum_err(out_cksum_err)
  );

  typedef struct {
    logic [31:0] d;
    logic        den, sof, sod, eof, err;
    string       tag_d, tag_s, tag_e;
  } exp_t;

  exp_t        hist [128];
  int          cyc = 0, total = 0, bad = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic logic [15:0] ones_fold(input logic [31:0] x);
    logic [31:0] v;
    v = x;
    while (v[31:16] != 16'd0) v = {16'd0, v[15:0]} + {16'd0, v[31:16]};
    return v[15:0];
  endfunction

  function automatic logic [31:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic step(input logic [31:0] d, input logic den, sof, sop, eof,
                      input logic esod, eerr, input logic [31:0] ed,
                      input string td, ts, te);
    exp_t e;
    logic ok;
    if (cyc < LAT2) begin
      e.d = '0; e.den = 0; e.sof = 0; e.sod = 0; e.eof = 0; e.err = 0;
      e.tag_d = "R9"; e.tag_s = "R9"; e.tag_e = "R9";
    end else begin
      e = hist[(cyc - LAT2) & 127];
    end
    total++;
    ok = 1'b1;
    if (out_data !== e.d || out_den !== e.den || out_sof !== e.sof || out_eof !== e.eof) begin
      ok = 1'b0;
      $display("FAIL %s data/strobes actual=%h/%b%b%b expected=%h/%b%b%b", e.tag_d,
               out_data, out_den, out_sof, out_eof, e.d, e.den, e.sof, e.eof);
    end
    if (out_sod !== e.sod) begin
      ok = 1'b0;
      $display("FAIL %s sod actual=%b expected=%b", e.tag_s, out_sod, e.sod);
    end
    if (out_cksum_err !== e.err) begin
      ok = 1'b0;
      $display("FAIL %s cksum_err actual=%b expected=%b", e.tag_e, out_cksum_err, e.err);
    end
    if (!ok) bad++;
    in_data = d; in_den = den; in_sof = sof; in_sop = sop; in_eof = eof;
    e.d = ed; e.den = den; e.sof = sof; e.sod = esod; e.eof = eof; e.err = eerr;
    e.tag_d = td; e.tag_s = ts; e.tag_e = te;
    hist[cyc & 127] = e;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(32'hDEAD_0000 | i, 0, 0, 0, 0, 0, 0, 32'hDEAD_0000 | i, "R8", "R8", "R8");
  endtask

  // mode: 0 correct checksum, 1 zero checksum (R7), 2 corrupted (R6)
  task automatic send_frame(input logic [7:0] proto, input int ihl, input int n,
                            input int mode, input bit gap, input bit odd);
    logic [31:0] w [64];
    logic [31:0] src, dst, sum;
    logic [15:0] ulen, c, rx, f;
    logic        udp, eerr;
    int          nw, sop_i, ck_i;
    string       ts, te, td;
    udp   = (proto == 8'd17);
    src   = next_rand();
    dst   = next_rand();
    ulen  = 16'(8 + 4 * n - (odd ? 1 : 0));
    sop_i = ihl;
    ck_i  = ihl + 1;
    nw    = ihl + 2 + n;
    w[0] = {4'h4, 4'(ihl), 8'h00, 16'(4 * ihl) + ulen};
    w[1] = {next_rand()[15:0], 16'h4000};
    w[2] = {8'd64, proto, next_rand()[15:0]};
    w[3] = src;
    w[4] = dst;
    if (ihl > 5) w[5] = 32'h0101_0101;
    w[sop_i] = next_rand();
    for (int i = 0; i < n; i++) w[ck_i + 1 + i] = next_rand();
    if (odd) w[nw - 1][7:0] = 8'h00;
    sum = {16'd0, src[31:16]} + src[15:0] + dst[31:16] + dst[15:0] + 32'd17 + ulen;
    sum = sum + w[sop_i][31:16] + w[sop_i][15:0] + ulen;
    for (int i = 0; i < n; i++) sum = sum + w[ck_i + 1 + i][31:16] + w[ck_i + 1 + i][15:0];
    f = ones_fold(sum);
    c = ~f;
    if (c == 16'd0) c = 16'hFFFF;
    rx = (mode == 0) ? c : (mode == 1) ? 16'd0 : (c ^ 16'h0100);
    w[ck_i] = {ulen, rx};
    eerr = udp && (mode == 2);
    ts = udp ? "R2" : "R1";
    te = (mode == 1) ? "R7" : "R6";
    for (int i = 0; i < nw; i++) begin
      td = !udp ? "R3" : (i == ck_i) ? "R5" : "R4";
      step(w[i], 1, i == 0, i == sop_i, i == nw - 1, udp && (i == sop_i),
           eerr && (i == nw - 1), (udp && i == ck_i) ? {ulen, c} : w[i], td, ts, te);
      if (gap && i[0]) step(32'hBAD0_0000 | i, 0, 0, 0, 0, 0, 0, 32'hBAD0_0000 | i, "R8", "R8", "R8");
    end
    step(32'hA5A5_0001, 1, 0, 0, 0, 0, 0, 32'hA5A5_0001, "R10", "R10", "R10");
    step(32'hA5A5_0002 ^ {ulen, 16'd0}, 1, 0, 0, 0, 0, 0, 32'hA5A5_0002 ^ {ulen, 16'd0}, "R10", "R10", "R10");
    idle(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] protos [6];
    protos[0] = 8'd17; protos[1] = 8'd6;    protos[2] = 8'd1;
    protos[3] = 8'h91; protos[4] = 8'h10;   protos[5] = 8'h13;
    rst = 1'b1;
    in_data = '0; in_den = 0; in_sof = 0; in_sop = 0; in_eof = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 checked during the first LAT2 steps
    for (int p = 0; p < 6; p++)
      for (int ihl = 5; ihl <= 6; ihl++)
        for (int n = 0; n <= 4; n++)
          for (int m = 0; m < ((p == 0) ? 3 : 1); m++)
            send_frame(protos[p], ihl, n, m, n[0], (n > 0) && (m == 0) && (ihl == 6));
    // long frame close to the delay window, gaps inside (R8, R5)
    send_frame(8'd17, 5, 30, 0, 1'b1, 1'b0);
    send_frame(8'd17, 6, 30, 2, 1'b1, 1'b1);
    send_frame(8'd6, 5, 30, 0, 1'b1, 1'b0);
    idle(LAT2 + 4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule